// File: doc/BRIEF.md
# Annotation-driven issue width limiter

This block decides, every clock cycle, how many instructions leave an in-order issue window for a bank of identical functional units. The window presents up to `NUM_SLOTS` instructions with slot 0 the oldest. Each slot carries a valid bit, a flag saying it depends on an earlier slot of the same group, a 2-bit rate tag placed by the compiler, and an operand word. The block takes a contiguous run of slots starting at slot 0, stopping at the first empty slot, at the first dependent slot, or at the width limit.

The width limit depends on a registered copy of the `over_temp` input. While that copy is low, the full width is allowed and the rate tags are ignored. While it is high, the rate tag of slot 0 caps the group, so the code itself chooses a narrower and cheaper issue pattern while the chip is hot. The operand of slot j goes to unit j, so with k units busy each unit sees stream items that are k positions apart. Units that are not loaded keep their previous operands.

The window follows a valid/ready handshake per slot. `win_valid[i]` is the offer and `slot_take[i]` is the combinational acceptance in the same cycle. A taken slot is consumed at the clock edge. Upstream must then shift the untaken slots toward slot 0 and present them again. A slot that is valid but not taken is back-pressured and must hold its contents.

Top module: `issue_width_limiter`

## Requirements
- R1: While `rst` is high at a clock edge, `slot_take` is 0. After that edge, `issue_mask`, `issue_cnt` and every unit operand read 0, and the throttle state is off. As a result, the first cycle after reset allows the full width even if `over_temp` was high during reset.
- R2: While the throttle state is off, up to `NUM_SLOTS` slots are taken whatever their rate tags are.
- R3: While the throttle state is on, the limit is set by the rate tag of slot 0, `win_rate[1:0]`, with codes 00, 01, 10 and 11 meaning 1, 2, 3 and 4 slots. The tags of the other slots have no effect.
- R4: The throttle state is `over_temp` sampled at the previous clock edge. A change on `over_temp` alters `slot_take` only in the cycle after the edge that samples it.
- R5: Taking is in order and contiguous from slot 0. An invalid slot stops the group, and nothing is taken when slot 0 is invalid.
- R6: The first slot i > 0 with `win_dep[i]` set is not taken, and neither is any slot after it. The dependence flag of slot 0 is ignored.
- R7: `issue_mask` and `issue_cnt` show, one cycle later, the `slot_take` value of the previous cycle and the number of ones in it.
- R8: One cycle after slot j is taken, unit j's operand (`unit_opnd[16j +: 16]` at the default width) equals the operand that slot j offered (`win_opnd[16j +: 16]`).
- R9: A unit whose slot was not taken keeps its operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| over_temp | input | 1 | Thermal trigger; sampled into the throttle state |
| win_valid | input | NUM_SLOTS | Per-slot offer, slot 0 oldest |
| win_dep | input | NUM_SLOTS | Slot depends on an earlier slot of the group |
| win_rate | input | 2*NUM_SLOTS | Per-slot rate tag, slot i at bits [2i+1:2i] |
| win_opnd | input | OPND_W*NUM_SLOTS | Per-slot operand, slot i at [OPND_W*i +: OPND_W] |
| slot_take | output | NUM_SLOTS | Per-slot acceptance (ready) in the current cycle |
| issue_mask | output | NUM_SLOTS | Registered copy of the previous cycle's acceptance |
| issue_cnt | output | $clog2(NUM_SLOTS+1) | Number of slots taken in the previous cycle |
| unit_opnd | output | OPND_W*NUM_SLOTS | Operand register of each unit |

## Verification
A stuck or stale throttle register shows up on `slot_take` in the first cycle after a change on `over_temp`. For that reason the bench checks both the cycle before the change takes effect and the cycle after it. A wrong limit or a broken stop condition shows up on `slot_take` in the same cycle, and then on `issue_mask` and `issue_cnt` one edge later. A unit register that loads when it should not, or takes data from the wrong slot, shows on `unit_opnd` one edge after the issue. The bench therefore loads distinct words into every unit first and then issues narrow groups, so that a wrong load or wrong routing produces a visible mismatch.

// File: rtl/iwl_pkg.sv
package iwl_pkg;
  localparam int RATE_W = 2;

  // Rate tag code to number of slots: code + 1.
  function automatic int unsigned rate_width(input logic [RATE_W-1:0] code);
    return int'(code) + 1;
  endfunction
endpackage

// File: rtl/iwl_limit_sel.sv
module iwl_limit_sel
  import iwl_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic              throttle,
  input  logic [RATE_W-1:0] head_rate,
  output logic [CNT_W-1:0]  limit
);
  logic [CNT_W-1:0] lim_full;
  logic [CNT_W-1:0] lim_tag;

  always_comb begin
    lim_full = CNT_W'(NUM_SLOTS);
    lim_tag  = CNT_W'(rate_width(head_rate));
    if (throttle && (lim_tag < lim_full)) limit = lim_tag;
    else                                  limit = lim_full;
  end
endmodule

// File: rtl/iwl_take_chain.sv
module iwl_take_chain #(
  parameter int NUM_SLOTS = 4,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 enable,
  input  logic [NUM_SLOTS-1:0] valid,
  input  logic [NUM_SLOTS-1:0] dep,
  input  logic [CNT_W-1:0]     limit,
  output logic [NUM_SLOTS-1:0] take
);
  logic [NUM_SLOTS:0] run;
  assign run[0] = enable;

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
    logic dep_ok;
    if (gi == 0) begin : g_head
      assign dep_ok = 1'b1;
    end else begin : g_tail
      assign dep_ok = ~dep[gi];
    end
    assign run[gi+1] = run[gi] & valid[gi] & dep_ok & (CNT_W'(gi) < limit);
    assign take[gi]  = run[gi+1];
  end
endmodule

// File: rtl/iwl_unit_bank.sv
module iwl_unit_bank #(
  parameter int NUM_SLOTS = 4,
  parameter int OPND_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SLOTS-1:0]        load,
  input  logic [OPND_W*NUM_SLOTS-1:0] din,
  output logic [OPND_W*NUM_SLOTS-1:0] dout
);
  for (genvar gu = 0; gu < NUM_SLOTS; gu++) begin : g_unit
    logic [OPND_W-1:0] q;

    always_ff @(posedge clk) begin
      if (rst)           q <= '0;
      else if (load[gu]) q <= din[OPND_W*gu +: OPND_W];
    end
    assign dout[OPND_W*gu +: OPND_W] = q;

    // R9: an idle unit keeps its operand
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !load[gu] |=> $stable(dout[OPND_W*gu +: OPND_W]));
  end
endmodule

// File: rtl/issue_width_limiter.sv
module issue_width_limiter
  import iwl_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int OPND_W    = 16,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        over_temp,
  input  logic [NUM_SLOTS-1:0]        win_valid,
  input  logic [NUM_SLOTS-1:0]        win_dep,
  input  logic [RATE_W*NUM_SLOTS-1:0] win_rate,
  input  logic [OPND_W*NUM_SLOTS-1:0] win_opnd,
  output logic [NUM_SLOTS-1:0]        slot_take,
  output logic [NUM_SLOTS-1:0]        issue_mask,
  output logic [CNT_W-1:0]            issue_cnt,
  output logic [OPND_W*NUM_SLOTS-1:0] unit_opnd
);
  logic             thr_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] take_cnt;

  iwl_limit_sel #(.NUM_SLOTS(NUM_SLOTS)) u_limit (
    .throttle  (thr_q),
    .head_rate (win_rate[RATE_W-1:0]),
    .limit     (limit)
  );

  iwl_take_chain #(.NUM_SLOTS(NUM_SLOTS)) u_chain (
    .enable (~rst),
    .valid  (win_valid),
    .dep    (win_dep),
    .limit  (limit),
    .take   (slot_take)
  );

  iwl_unit_bank #(.NUM_SLOTS(NUM_SLOTS), .OPND_W(OPND_W)) u_units (
    .clk  (clk),
    .rst  (rst),
    .load (slot_take),
    .din  (win_opnd),
    .dout (unit_opnd)
  );

  always_comb begin
    take_cnt = '0;
    for (int i = 0; i < NUM_SLOTS; i++) take_cnt = take_cnt + CNT_W'(slot_take[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q      <= 1'b0;
      issue_mask <= '0;
      issue_cnt  <= '0;
    end else begin
      thr_q      <= over_temp;
      issue_mask <= slot_take;
      issue_cnt  <= take_cnt;
    end
  end

  // R1: registered outputs are cleared by reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (issue_mask == '0 && issue_cnt == '0));

  // R2: with the throttle off, a clean full window is taken whole
  assert_cool_full_R2: assert property (@(posedge clk) disable iff (rst)
    (!thr_q && (&win_valid) && (win_dep[NUM_SLOTS-1:1] == '0)) |-> (&slot_take));

  // R3: with the throttle on, the group never exceeds the head tag
  assert_throttle_cap_R3: assert property (@(posedge clk) disable iff (rst)
    thr_q |-> ($countones(slot_take) <= (int'(win_rate[RATE_W-1:0]) + 1)));

  // R5: the registered mask is a contiguous run from slot 0
  assert_prefix_R5: assert property (@(posedge clk) disable iff (rst)
    ((NUM_SLOTS'(issue_mask + NUM_SLOTS'(1)) & issue_mask) == '0));

  // R7: count agrees with the mask
  assert_cnt_match_R7: assert property (@(posedge clk) disable iff (rst)
    (int'(issue_cnt) == $countones(issue_mask)));

  for (genvar gd = 1; gd < NUM_SLOTS; gd++) begin : g_dep_chk
    // R6: a dependent slot is never taken
    assert_dep_stop_R6: assert property (@(posedge clk) disable iff (rst)
      win_dep[gd] |-> !slot_take[gd]);
  end
endmodule

// File: tb/issue_width_limiter_tb.sv
module issue_width_limiter_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        over_temp;
  logic [3:0]  win_valid;
  logic [3:0]  win_dep;
  logic [7:0]  win_rate;
  logic [63:0] win_opnd;
  logic [3:0]  slot_take;
  logic [3:0]  issue_mask;
  logic [2:0]  issue_cnt;
  logic [63:0] unit_opnd;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  issue_width_limiter u_dut (
    .clk(clk), .rst(rst), .over_temp(over_temp),
    .win_valid(win_valid), .win_dep(win_dep), .win_rate(win_rate), .win_opnd(win_opnd),
    .slot_take(slot_take), .issue_mask(issue_mask), .issue_cnt(issue_cnt),
    .unit_opnd(unit_opnd)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic hot, input logic [3:0] v, input logic [3:0] d,
                       input logic [7:0] r, input logic [63:0] op);
    over_temp = hot; win_valid = v; win_dep = d; win_rate = r; win_opnd = op;
  endtask

  // One cycle: drive, check acceptance, cross an edge, check registered outputs.
  task automatic cycle(input string req, input logic hot, input logic [3:0] v,
                       input logic [3:0] d, input logic [7:0] r, input logic [63:0] op,
                       input logic [3:0] exp_take, input logic [2:0] exp_cnt);
    drive(hot, v, d, r, op);
    #1 chk({req, " slot_take"}, 64'(slot_take), 64'(exp_take));
    @(negedge clk);
    chk("R7 issue_mask", 64'(issue_mask), 64'(exp_take));
    chk("R7 issue_cnt", 64'(issue_cnt), 64'(exp_cnt));
  endtask

  task automatic settle(input logic hot);
    drive(hot, 4'h0, 4'h0, 8'h00, 64'h0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    drive(1'b1, 4'hF, 4'h0, 8'h00, 64'h1234_5678_9abc_def0);
    @(negedge clk); @(negedge clk);
    chk("R1 take in reset", 64'(slot_take), 64'h0);
    chk("R1 mask", 64'(issue_mask), 64'h0);
    chk("R1 cnt", 64'(issue_cnt), 64'h0);
    chk("R1 units", unit_opnd, 64'h0);
    rst = 1'b0;
    // throttle state still off although over_temp was high
    cycle("R1 full after reset", 1'b1, 4'hF, 4'h0, 8'h00, 64'h1234_5678_9abc_def0, 4'hF, 3'd4);
    #1 chk("R4 throttle now on", 64'(slot_take), 64'h1);
    settle(1'b0);
    settle(1'b0);
  endtask

  task automatic t_cool_full;
    cycle("R2 rate tag ignored", 1'b0, 4'hF, 4'h0, 8'h00, 64'h4444_3333_2222_1111, 4'hF, 3'd4);
    chk("R8 all units loaded", unit_opnd, 64'h4444_3333_2222_1111);
  endtask

  task automatic t_rates;
    settle(1'b1);
    for (int r = 0; r < 4; r++) begin
      logic [7:0]  tags;
      logic [3:0]  m;
      tags = {2'(3 - r), 2'(3 - r), 2'(3 - r), 2'(r)};
      m    = 4'((1 << (r + 1)) - 1);
      cycle("R3 head tag sets limit", 1'b1, 4'hF, 4'h0, tags, 64'h0, m, 3'(r + 1));
    end
  endtask

  task automatic t_latency;
    settle(1'b0);
    drive(1'b1, 4'hF, 4'h0, 8'h00, 64'h0);
    #1 chk("R4 rise not yet seen", 64'(slot_take), 64'hF);
    @(negedge clk);
    #1 chk("R4 rise applied", 64'(slot_take), 64'h1);
    drive(1'b0, 4'hF, 4'h0, 8'h00, 64'h0);
    #1 chk("R4 fall not yet seen", 64'(slot_take), 64'h1);
    @(negedge clk);
    #1 chk("R4 fall applied", 64'(slot_take), 64'hF);
    @(negedge clk);
  endtask

  task automatic t_dep;
    settle(1'b0);
    cycle("R6 dep slot2", 1'b0, 4'hF, 4'b0100, 8'h00, 64'h0, 4'b0011, 3'd2);
    cycle("R6 dep slot0 ignored", 1'b0, 4'hF, 4'b0001, 8'h00, 64'h0, 4'hF, 3'd4);
    cycle("R6 dep slot3", 1'b0, 4'hF, 4'b1000, 8'h00, 64'h0, 4'b0111, 3'd3);
    settle(1'b1);
    cycle("R6 dep under throttle", 1'b1, 4'hF, 4'b1000, 8'h03, 64'h0, 4'b0111, 3'd3);
    cycle("R6 limit before dep", 1'b1, 4'hF, 4'b1000, 8'h01, 64'h0, 4'b0011, 3'd2);
    settle(1'b0);
  endtask

  task automatic t_hole;
    settle(1'b0);
    cycle("R5 hole at slot1", 1'b0, 4'b1101, 4'h0, 8'h00, 64'h0, 4'b0001, 3'd1);
    cycle("R5 head empty", 1'b0, 4'b1110, 4'h0, 8'h00, 64'h0, 4'b0000, 3'd0);
    cycle("R5 hole at slot3", 1'b0, 4'b0111, 4'h0, 8'h00, 64'h0, 4'b0111, 3'd3);
  endtask

  task automatic t_hold;
    settle(1'b0);
    cycle("R8 load all", 1'b0, 4'hF, 4'h0, 8'h00, 64'hAAAA_BBBB_CCCC_DDDD, 4'hF, 3'd4);
    chk("R8 units A", unit_opnd, 64'hAAAA_BBBB_CCCC_DDDD);
    cycle("R9 narrow issue", 1'b0, 4'hF, 4'b0010, 8'h00, 64'h1111_2222_3333_4444, 4'b0001, 3'd1);
    chk("R9 units 1..3 held", unit_opnd, 64'hAAAA_BBBB_CCCC_4444);
    cycle("R9 empty window", 1'b0, 4'h0, 4'h0, 8'h00, 64'h5555_6666_7777_8888, 4'h0, 3'd0);
    chk("R9 all held", unit_opnd, 64'hAAAA_BBBB_CCCC_4444);
    settle(1'b1);
    cycle("R8 throttled pair", 1'b1, 4'hF, 4'h0, 8'h01, 64'h9999_8888_7777_6666, 4'b0011, 3'd2);
    chk("R8 units 0..1 loaded", unit_opnd, 64'hAAAA_BBBB_7777_6666);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired, run did not complete");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 4'h0, 4'h0, 8'h00, 64'h0);
    @(negedge clk);
    t_reset();
    t_cool_full();
    t_rates();
    t_latency();
    t_dep();
    t_hole();
    t_hold();
    finish_run();
  end
endmodule